// File: doc/BRIEF.md
# Table-Driven Call, Switch and Return Branch Unit

This unit works out the next program counter for two control transfers that take their target from a table of halfword offsets held in memory, and for the return that matches the table call. For a table call, the entry address is formed from a base register and a small immediate index. The halfword read from that entry is added to the base to give the target. The call also puts the return address and the current status word into dedicated save registers. For a switch, the table starts directly after the two-byte instruction and is indexed by a register value. The signed table entry, scaled by two, is added to the address that follows the instruction.

Each table transfer makes exactly one halfword read through a simple request/response port. The unit holds the request until the response arrives, then presents the target with a one-cycle valid pulse. A return reads no memory. It presents the saved return address with bit 0 cleared and restores the status word through a writable-bits mask. The unit takes one command at a time and signals busy while a command is in flight.

Top module: `tbl_branch_unit`

## Requirements
- R1: After reset, busy, mem_req, tgt_valid and status_wr are 0, and saved_pc and saved_status are 0.
- R2: A call command (cmd_op = 2'b00) accepted while idle raises mem_req in the next cycle. The address is (base_addr with bit 0 cleared) + (cmd_index << 1).
- R3: While mem_req is high and mem_valid is low, mem_req stays high in the next cycle and mem_addr does not change.
- R4: For a call, in the cycle after mem_valid, tgt_valid is high for exactly one cycle. tgt_pc then equals (base_addr with bit 0 cleared) + (mem_rdata with bit 0 cleared, zero-extended).
- R5: An accepted call loads saved_pc with cur_pc + 2 and saved_status with cur_status. Both are visible from the cycle after acceptance.
- R6: A switch command (cmd_op = 2'b01) accepted while idle raises mem_req in the next cycle. The address is cur_pc + 2 + (index_val << 1).
- R7: For a switch, in the cycle after mem_valid, tgt_valid pulses for one cycle. tgt_pc then equals cur_pc + 2 + (sign-extended mem_rdata << 1).
- R8: A return command (cmd_op = 2'b10) accepted while idle makes no memory request. In the next cycle it gives one cycle of tgt_valid and status_wr, with tgt_pc = saved_pc with bit 0 cleared and status_out = saved_status & status_mask.
- R9: busy is high from the cycle after acceptance up to and including the tgt_valid cycle. Commands presented while busy are ignored, and so is cmd_op = 2'b11.
- R10: Switch and return commands leave saved_pc and saved_status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_op | input | 2 | 00 call, 01 switch, 10 return, 11 no operation |
| cur_pc | input | 32 | Address of the current instruction |
| base_addr | input | 32 | Table base register for a call |
| cmd_index | input | 6 | Call table index |
| index_val | input | 32 | Switch index register value |
| cur_status | input | 32 | Current status word |
| status_mask | input | 32 | Writable status bits applied on return |
| busy | output | 1 | A command is in flight |
| mem_req | output | 1 | Halfword read request |
| mem_addr | output | 32 | Read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read halfword |
| tgt_valid | output | 1 | One-cycle pulse: tgt_pc is the next PC |
| tgt_pc | output | 32 | Next program counter |
| status_wr | output | 1 | One-cycle pulse: load status_out into the status word |
| status_out | output | 32 | Restored status word |
| saved_pc | output | 32 | Saved return address |
| saved_status | output | 32 | Saved status word |

## Verification
The assertions assume that mem_valid arrives only while mem_req is high. They also assume that status_mask does not change between accepting a return and its status_wr pulse. The bench's memory model drives mem_valid for exactly one cycle, and only after it has seen the request. It holds status_mask at one value for the whole run. Each table transfer is run with a different response latency, from zero to four waiting cycles, so that the hold rule is exercised both with and without stall cycles.

// File: rtl/tbl_branch_pkg.sv
package tbl_branch_pkg;

    typedef enum logic [1:0] {
        OP_CALL   = 2'b00,
        OP_SWITCH = 2'b01,
        OP_RETURN = 2'b10,
        OP_NONE   = 2'b11
    } br_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_MEM  = 2'b01,
        ST_FIN  = 2'b10
    } br_state_e;

endpackage

// File: rtl/tbl_entry_addr.sv
module tbl_entry_addr
    import tbl_branch_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IDX_W = 6
) (
    input  br_op_e            op,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   base,
    input  logic [XLEN-1:0]   index_val,
    input  logic [IDX_W-1:0]  idx,
    output logic [XLEN-1:0]   anchor,
    output logic [XLEN-1:0]   entry
);
    localparam logic [XLEN-1:0] EVEN_MASK = {{(XLEN-1){1'b1}}, 1'b0};
    localparam logic [XLEN-1:0] INSN_LEN  = XLEN'(2);

    logic [XLEN-1:0] pc_after;
    logic [XLEN-1:0] base_even;

    assign pc_after  = pc + INSN_LEN;
    assign base_even = base & EVEN_MASK;

    always_comb begin
        if (op == OP_CALL) begin
            anchor = base_even;
            entry  = base_even + (XLEN'(idx) << 1);
        end else begin
            anchor = pc_after;
            entry  = pc_after + (index_val << 1);
        end
    end

endmodule

// File: rtl/tbl_target_calc.sv
module tbl_target_calc #(
    parameter int XLEN = 32,
    parameter int HW   = 16
) (
    input  logic            is_call,
    input  logic [XLEN-1:0] anchor,
    input  logic [HW-1:0]   half,
    output logic [XLEN-1:0] target
);
    logic [XLEN-1:0] call_off;
    logic [XLEN-1:0] sw_off;

    assign call_off = {{(XLEN-HW){1'b0}}, half[HW-1:1], 1'b0};
    assign sw_off   = {{(XLEN-HW){half[HW-1]}}, half} << 1;

    always_comb begin
        if (is_call) target = anchor + call_off;
        else         target = anchor + sw_off;
    end

endmodule

// File: rtl/tbl_branch_unit.sv
module tbl_branch_unit
    import tbl_branch_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IDX_W = 6,
    parameter int HW    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   base_addr,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic [XLEN-1:0]   index_val,
    input  logic [XLEN-1:0]   cur_status,
    input  logic [XLEN-1:0]   status_mask,
    output logic              busy,
    output logic              mem_req,
    output logic [XLEN-1:0]   mem_addr,
    input  logic              mem_valid,
    input  logic [HW-1:0]     mem_rdata,
    output logic              tgt_valid,
    output logic [XLEN-1:0]   tgt_pc,
    output logic              status_wr,
    output logic [XLEN-1:0]   status_out,
    output logic [XLEN-1:0]   saved_pc,
    output logic [XLEN-1:0]   saved_status
);
    localparam logic [XLEN-1:0] EVEN_MASK = {{(XLEN-1){1'b1}}, 1'b0};
    localparam logic [XLEN-1:0] INSN_LEN  = XLEN'(2);

    typedef struct packed {
        br_state_e       st;
        br_op_e          op;
        logic [XLEN-1:0] anchor;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] tgt;
        logic [XLEN-1:0] spc;
        logic [XLEN-1:0] sst;
        logic [XLEN-1:0] stat;
        logic            tv;
        logic            sw;
    } regs_t;

    regs_t r_d, r_q;

    br_op_e          op_in;
    logic [XLEN-1:0] anchor_c;
    logic [XLEN-1:0] entry_c;
    logic [XLEN-1:0] target_c;
    logic            accept;

    assign op_in  = br_op_e'(cmd_op);
    assign accept = cmd_valid && (op_in != OP_NONE) && (r_q.st == ST_IDLE);

    tbl_entry_addr #(.XLEN(XLEN), .IDX_W(IDX_W)) u_entry (
        .op        (op_in),
        .pc        (cur_pc),
        .base      (base_addr),
        .index_val (index_val),
        .idx       (cmd_index),
        .anchor    (anchor_c),
        .entry     (entry_c)
    );

    tbl_target_calc #(.XLEN(XLEN), .HW(HW)) u_target (
        .is_call (r_q.op == OP_CALL),
        .anchor  (r_q.anchor),
        .half    (mem_rdata),
        .target  (target_c)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.op = op_in;
                    if (op_in == OP_RETURN) begin
                        r_d.tgt  = r_q.spc & EVEN_MASK;
                        r_d.stat = r_q.sst & status_mask;
                        r_d.sw   = 1'b1;
                        r_d.tv   = 1'b1;
                        r_d.st   = ST_FIN;
                    end else begin
                        r_d.anchor = anchor_c;
                        r_d.addr   = entry_c;
                        r_d.st     = ST_MEM;
                        if (op_in == OP_CALL) begin
                            r_d.spc = cur_pc + INSN_LEN;
                            r_d.sst = cur_status;
                        end
                    end
                end
            end
            ST_MEM: begin
                if (mem_valid) begin
                    r_d.tgt = target_c;
                    r_d.tv  = 1'b1;
                    r_d.st  = ST_FIN;
                end
            end
            ST_FIN: begin
                r_d.tv = 1'b0;
                r_d.sw = 1'b0;
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.op     <= OP_NONE;
            r_q.anchor <= '0;
            r_q.addr   <= '0;
            r_q.tgt    <= '0;
            r_q.spc    <= '0;
            r_q.sst    <= '0;
            r_q.stat   <= '0;
            r_q.tv     <= 1'b0;
            r_q.sw     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy         = (r_q.st != ST_IDLE);
    assign mem_req      = (r_q.st == ST_MEM);
    assign mem_addr     = r_q.addr;
    assign tgt_valid    = r_q.tv;
    assign tgt_pc       = r_q.tgt;
    assign status_wr    = r_q.sw;
    assign status_out   = r_q.stat;
    assign saved_pc     = r_q.spc;
    assign saved_status = r_q.sst;

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    assert_pulse_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |=> !tgt_valid);

    assert_busy_cover_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || tgt_valid) |-> busy);

    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(cmd_valid && cmd_op != 2'b11)) |=> !busy);

    assert_ret_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
        status_wr |-> (tgt_valid && !mem_req && !tgt_pc[0]
                       && ((status_out & ~status_mask) == '0)));

    assert_saved_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(saved_pc) && $stable(saved_status)));

endmodule

// File: tb/sim_tbl_branch_unit.sv
module sim_tbl_branch_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] pc;
        logic [31:0] base;
        logic [5:0]  idx;
        logic [31:0] index;
        logic [31:0] status;
        logic [15:0] rdata;
        logic [31:0] exp_addr;
        logic [31:0] exp_tgt;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 32'h0000_0100, 32'h0000_1001, 6'd5,  32'h0,        32'h0000_00A5, 16'h0043, 32'h0000_100A, 32'h0000_1042},
        '{2'b00, 32'h0000_2FFE, 32'h2000_0000, 6'd63, 32'h0,        32'hFFFF_FFFF, 16'hFFFF, 32'h2000_007E, 32'h2000_FFFE},
        '{2'b01, 32'h0000_0400, 32'h0,         6'd0,  32'h0000_0003, 32'h0,        16'h0010, 32'h0000_0408, 32'h0000_0422},
        '{2'b01, 32'h0000_1000, 32'h0,         6'd0,  32'h0000_0000, 32'h0,        16'hFFFE, 32'h0000_1002, 32'h0000_0FFE},
        '{2'b01, 32'h0000_8000, 32'h0,         6'd0,  32'h0000_0010, 32'h0,        16'h8000, 32'h0000_8022, 32'hFFFF_8002}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b11;
    logic [31:0] cur_pc = '0;
    logic [31:0] base_addr = '0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] index_val = '0;
    logic [31:0] cur_status = '0;
    logic [31:0] status_mask = 32'h0000_FF0F;
    logic        mem_valid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        busy, mem_req, tgt_valid, status_wr;
    logic [31:0] mem_addr, tgt_pc, status_out, saved_pc, saved_status;

    int n_tests = 0;
    int n_fail = 0;
    logic [31:0] exp_spc = '0;
    logic [31:0] exp_sst = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbl_branch_unit u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cur_pc(cur_pc), .base_addr(base_addr), .cmd_index(cmd_index),
        .index_val(index_val), .cur_status(cur_status), .status_mask(status_mask),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .tgt_valid(tgt_valid), .tgt_pc(tgt_pc), .status_wr(status_wr),
        .status_out(status_out), .saved_pc(saved_pc), .saved_status(saved_status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int lat);
        string ra, rt;
        ra = (v.op == 2'b00) ? "R2" : "R6";
        rt = (v.op == 2'b00) ? "R4" : "R7";
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = v.op; cur_pc = v.pc; base_addr = v.base;
        cmd_index = v.idx; index_val = v.index; cur_status = v.status;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b11;
        chk(ra, {31'b0, mem_req}, 32'd1);
        chk(ra, mem_addr, v.exp_addr);
        chk("R9", {31'b0, busy}, 32'd1);
        if (v.op == 2'b00) begin
            exp_spc = v.pc + 32'd2;
            exp_sst = v.status;
            chk("R5", saved_pc, exp_spc);
            chk("R5", saved_status, exp_sst);
        end else begin
            chk("R10", saved_pc, exp_spc);
            chk("R10", saved_status, exp_sst);
        end
        for (int k = 0; k < lat; k++) begin
            @(negedge clk);
            chk("R3", {31'b0, mem_req}, 32'd1);
            chk("R3", mem_addr, v.exp_addr);
        end
        mem_valid = 1'b1; mem_rdata = v.rdata;
        @(negedge clk);
        mem_valid = 1'b0;
        chk(rt, {31'b0, tgt_valid}, 32'd1);
        chk(rt, tgt_pc, v.exp_tgt);
        chk("R9", {31'b0, busy}, 32'd1);
        chk(rt, {31'b0, mem_req}, 32'd0);
        @(negedge clk);
        chk(rt, {31'b0, tgt_valid}, 32'd0);
        chk("R9", {31'b0, busy}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", {31'b0, busy}, 32'd0);
        chk("R1", {31'b0, mem_req}, 32'd0);
        chk("R1", {31'b0, tgt_valid}, 32'd0);
        chk("R1", {31'b0, status_wr}, 32'd0);
        chk("R1", saved_pc, 32'd0);
        chk("R1", saved_status, 32'd0);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i);

        // R9: op 11 does nothing
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b11;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R9", {31'b0, busy}, 32'd0);
        chk("R9", {31'b0, mem_req}, 32'd0);
        chk("R9", {31'b0, tgt_valid}, 32'd0);

        // Call with odd PC, then a command while busy is ignored (R9)
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b00; cur_pc = 32'h0000_0501;
        base_addr = 32'h0000_0010; cmd_index = 6'd0; cur_status = 32'h1234_5678;
        @(negedge clk);
        cmd_op = 2'b01; cur_pc = 32'h0000_9000; index_val = 32'd5;
        cur_status = 32'hDEAD_BEEF;
        chk("R2", mem_addr, 32'h0000_0010);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b11;
        chk("R9", mem_addr, 32'h0000_0010);
        chk("R5", saved_pc, 32'h0000_0503);
        chk("R5", saved_status, 32'h1234_5678);
        mem_valid = 1'b1; mem_rdata = 16'h0004;
        @(negedge clk);
        mem_valid = 1'b0;
        chk("R4", tgt_pc, 32'h0000_0014);
        @(negedge clk);
        chk("R9", {31'b0, busy}, 32'd0);
        chk("R9", saved_pc, 32'h0000_0503);

        // R8: return
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b10; cur_status = 32'hFFFF_FFFF; cur_pc = 32'h0000_7777;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b11;
        chk("R8", {31'b0, tgt_valid}, 32'd1);
        chk("R8", {31'b0, status_wr}, 32'd1);
        chk("R8", tgt_pc, 32'h0000_0502);
        chk("R8", status_out, 32'h0000_5608);
        chk("R8", {31'b0, mem_req}, 32'd0);
        chk("R9", {31'b0, busy}, 32'd1);
        chk("R10", saved_pc, 32'h0000_0503);
        chk("R10", saved_status, 32'h1234_5678);
        @(negedge clk);
        chk("R8", {31'b0, status_wr}, 32'd0);
        chk("R8", {31'b0, tgt_valid}, 32'd0);
        chk("R9", {31'b0, busy}, 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule